// File: doc/BRIEF.md
# Supply Trip Threshold Programming Sequencer

This block sits beside the command decoder of a serial memory that also supervises the supply. It watches the decoded command stream and picks out two special memory writes. A fixed key byte written to one fixed address asks for the supply trip threshold to be raised to the present supply level. The same key byte written to a second fixed address asks for the threshold to go back to its native low level. Both writes are still ordinary array writes, and the block does not stop them reaching the array.

A request only counts when four things hold. A write-enable command came first. The write carries exactly the key byte to one of the two addresses. The write-protect pin shows the high programming voltage, seen here as a digitised flag. The chip-select rising edge ends the write. When all four hold, the block gives a one-clock pulse on one of its two outputs to the trimming circuit. It then holds `busy` high until the high-voltage flag falls. The flag passes through a configurable synchronizer before use.

Top module: `thr_prog_seq`

## Requirements
- R1: After reset `set_pulse`, `clr_pulse` and `busy` are all low, and no write-enable is armed.
- R2: Three steps, in order, raise the threshold: a write-enable event, a write event with data 00h to address 01h, then a chip-select rising edge, all while the synchronized high-voltage flag is high. In the clock after that chip-select edge, `set_pulse` is high for exactly one cycle.
- R3: The same sequence aimed at address 03h with data 00h makes `clr_pulse` high for exactly one cycle instead.
- R4: A write that no write-enable event has armed is ignored, and no pulse results.
- R5: A write with any data other than 00h, or to any address other than 01h or 03h, gives no pulse.
- R6: If the synchronized high-voltage flag is low while the write waits for chip-select, or when chip-select rises, the request is dropped and no pulse follows.
- R7: `busy` rises with the pulse. It stays high while the flag is high, and it falls one clock after the synchronized flag goes low, which is SYNC_STAGES+1 clock edges after `hv_in` falls.
- R8: The chip-select rising edge that ends a write, whether it qualifies or not, disarms the write-enable. A later write needs a fresh write-enable event.
- R9: While `busy` is high, write-enable and write events are ignored. No pulse results from them, and no write-enable is left armed afterwards.
- R10: `set_pulse` and `clr_pulse` are never high together and never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren_evt | input | 1 | One-cycle strobe: a write-enable command was decoded |
| wr_evt | input | 1 | One-cycle strobe: a write byte was decoded |
| wr_addr | input | ADDR_W | Array address of the decoded write |
| wr_data | input | DATA_W | Data byte of the decoded write |
| cs_rise | input | 1 | One-cycle strobe: chip-select deasserted |
| hv_in | input | 1 | Raw flag: write-protect pin is at the programming voltage |
| set_pulse | output | 1 | One-cycle request to raise the trip threshold |
| clr_pulse | output | 1 | One-cycle request to restore the native threshold |
| busy | output | 1 | Programming in progress, waiting for the flag to drop |

## Verification
The bench builds the block with an 8-bit address and a three-stage flag synchronizer. With an 8-bit address, the addresses next to the two special ones can be reached, and data values other than the key can be tried. With three synchronizer stages, the R7 latency becomes a distinct count that the bench samples on both sides of the edge. It also leaves room for a flag drop that cancels a pending request before chip-select rises.

// File: rtl/thr_pkg.sv
package thr_pkg;

   typedef enum logic [1:0] {
      OP_NONE    = 2'd0,
      OP_RAISE   = 2'd1,
      OP_RESTORE = 2'd2
   } thr_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_HOLD  = 2'd2
   } thr_state_e;

endpackage

// File: rtl/thr_hv_sync.sv
module thr_hv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else if (STAGES == 1) begin
               chain_q <= d_in;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], d_in};
            end
         end
         assign d_out = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/thr_cmd_match.sv
module thr_cmd_match
   import thr_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int DATA_W    = 8,
   parameter int RAISE_ADR = 1,
   parameter int REST_ADR  = 3,
   parameter int KEY_BYTE  = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output thr_op_e           op
);

   localparam logic [ADDR_W-1:0] RaiseA = ADDR_W'(RAISE_ADR);
   localparam logic [ADDR_W-1:0] RestA  = ADDR_W'(REST_ADR);
   localparam logic [DATA_W-1:0] KeyV   = DATA_W'(KEY_BYTE);

   always_comb begin
      op = OP_NONE;
      if (data == KeyV) begin
         if (addr == RaiseA) begin
            op = OP_RAISE;
         end else if (addr == RestA) begin
            op = OP_RESTORE;
         end
      end
   end

endmodule

// File: rtl/thr_seq_ctl.sv
module thr_seq_ctl
   import thr_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wren_evt,
   input  logic    wr_evt,
   input  thr_op_e wr_op,
   input  logic    cs_rise,
   input  logic    hv_ok,
   output logic    set_pulse,
   output logic    clr_pulse,
   output logic    busy
);

   thr_state_e state_q;
   thr_op_e    op_q;
   logic       wel_q;
   logic       set_q;
   logic       clr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_NONE;
         wel_q   <= 1'b0;
         set_q   <= 1'b0;
         clr_q   <= 1'b0;
      end else begin
         set_q <= 1'b0;
         clr_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (wren_evt) begin
                  wel_q <= 1'b1;
               end
               if (wr_evt && wel_q) begin
                  op_q    <= hv_ok ? wr_op : OP_NONE;
                  state_q <= ST_ARMED;
               end
            end
            ST_ARMED: begin
               if (cs_rise) begin
                  wel_q <= 1'b0;
                  op_q  <= OP_NONE;
                  if (hv_ok && op_q == OP_RAISE) begin
                     set_q   <= 1'b1;
                     state_q <= ST_HOLD;
                  end else if (hv_ok && op_q == OP_RESTORE) begin
                     clr_q   <= 1'b1;
                     state_q <= ST_HOLD;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end else if (!hv_ok) begin
                  op_q <= OP_NONE;
               end
            end
            ST_HOLD: begin
               wel_q <= 1'b0;
               if (!hv_ok) begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign set_pulse = set_q;
   assign clr_pulse = clr_q;
   assign busy      = (state_q == ST_HOLD);

endmodule

// File: rtl/thr_prog_seq.sv
module thr_prog_seq
   import thr_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 8,
   parameter int RAISE_ADR   = 1,
   parameter int REST_ADR    = 3,
   parameter int KEY_BYTE    = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wren_evt,
   input  logic              wr_evt,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cs_rise,
   input  logic              hv_in,
   output logic              set_pulse,
   output logic              clr_pulse,
   output logic              busy
);

   localparam longint AddrSpan = longint'(1) << ADDR_W;
   localparam longint DataSpan = longint'(1) << DATA_W;

   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_aw
         $error("thr_prog_seq: ADDR_W out of range");
      end
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_dw
         $error("thr_prog_seq: DATA_W out of range");
      end
      if (RAISE_ADR == REST_ADR) begin : g_bad_same
         $error("thr_prog_seq: the two special addresses must differ");
      end
      if (longint'(RAISE_ADR) >= AddrSpan || longint'(REST_ADR) >= AddrSpan) begin : g_bad_adr
         $error("thr_prog_seq: special address beyond ADDR_W");
      end
      if (longint'(KEY_BYTE) >= DataSpan) begin : g_bad_key
         $error("thr_prog_seq: KEY_BYTE beyond DATA_W");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 8) begin : g_bad_sync
         $error("thr_prog_seq: SYNC_STAGES out of range");
      end
   endgenerate

   logic    hv_ok;
   thr_op_e wr_op;

   thr_hv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (hv_in),
      .d_out (hv_ok)
   );

   thr_cmd_match #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .RAISE_ADR (RAISE_ADR),
      .REST_ADR  (REST_ADR),
      .KEY_BYTE  (KEY_BYTE)
   ) u_match (
      .addr (wr_addr),
      .data (wr_data),
      .op   (wr_op)
   );

   thr_seq_ctl u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wren_evt  (wren_evt),
      .wr_evt    (wr_evt),
      .wr_op     (wr_op),
      .cs_rise   (cs_rise),
      .hv_ok     (hv_ok),
      .set_pulse (set_pulse),
      .clr_pulse (clr_pulse),
      .busy      (busy)
   );

endmodule

// File: rtl/thr_prog_seq_chk.sv
module thr_prog_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_rise,
   input logic set_pulse,
   input logic clr_pulse,
   input logic busy
);

   assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_pulse && clr_pulse));

   assert_set_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse |=> !set_pulse);

   assert_clr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> !clr_pulse);

   assert_busy_with_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_pulse || clr_pulse) |-> busy);

   assert_pulse_after_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_pulse || clr_pulse) |-> $past(cs_rise));

   assert_no_pulse_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (set_pulse || clr_pulse) |-> !$past(busy));

   assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (set_pulse || clr_pulse));

endmodule

bind thr_prog_seq thr_prog_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_rise   (cs_rise),
   .set_pulse (set_pulse),
   .clr_pulse (clr_pulse),
   .busy      (busy)
);

// File: tb/thr_prog_seq_test.sv
module thr_prog_seq_test;

   localparam int AW = 8;
   localparam int DW = 8;
   localparam int SYNC = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wren_evt = 1'b0;
   logic          wr_evt = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          cs_rise = 1'b0;
   logic          hv_in = 1'b0;
   logic          set_pulse;
   logic          clr_pulse;
   logic          busy;

   int    errors = 0;
   int    checks = 0;
   int    exp_q[$];
   string cur_req = "R1";
   bit    done = 1'b0;
   bit    prev_pulse = 1'b0;

   always #4 clk = ~clk;

   thr_prog_seq #(
      .ADDR_W      (AW),
      .DATA_W      (DW),
      .SYNC_STAGES (SYNC)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wren_evt  (wren_evt),
      .wr_evt    (wr_evt),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .cs_rise   (cs_rise),
      .hv_in     (hv_in),
      .set_pulse (set_pulse),
      .clr_pulse (clr_pulse),
      .busy      (busy)
   );

   task automatic chk(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard on every pulse.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (set_pulse || clr_pulse) begin
            int kind;
            kind = set_pulse ? 1 : 2;
            chk(int'(set_pulse && clr_pulse), 0, "R10 both pulses");
            chk(int'(prev_pulse), 0, "R10 pulse wider than one cycle");
            if (exp_q.size() == 0) begin
               chk(kind, 0, {cur_req, " unexpected pulse"});
            end else begin
               chk(kind, exp_q.pop_front(), {cur_req, " pulse kind"});
            end
         end
         prev_pulse = set_pulse || clr_pulse;
      end
   end

   task automatic hv_set(input bit v);
      @(negedge clk);
      hv_in = v;
      repeat (SYNC + 3) @(negedge clk);
   endtask

   // Driver: one command frame, expected pulse pushed to the scoreboard.
   task automatic txn(input bit wren, input int addr, input int data,
                      input bit drop, input int exp, input string req);
      cur_req = req;
      if (wren) begin
         @(negedge clk) wren_evt = 1'b1;
         @(negedge clk) wren_evt = 1'b0; cs_rise = 1'b1;
         @(negedge clk) cs_rise = 1'b0;
      end
      @(negedge clk) wr_evt = 1'b1; wr_addr = AW'(addr); wr_data = DW'(data);
      @(negedge clk) wr_evt = 1'b0;
      if (drop) begin
         hv_in = 1'b0;
         repeat (SYNC + 3) @(negedge clk);
      end
      if (exp != 0) exp_q.push_back(exp);
      cs_rise = 1'b1;
      @(negedge clk) cs_rise = 1'b0;
      repeat (2) @(negedge clk);
      chk(exp_q.size(), 0, {req, " scoreboard drained"});
   endtask

   // Busy hold and release timing after a programming pulse (R7).
   task automatic finish_hold(input string req);
      repeat (5) @(negedge clk);
      chk(int'(busy), 1, {req, " R7 busy held while flag high"});
      hv_in = 1'b0;
      repeat (SYNC) @(negedge clk);
      chk(int'(busy), 1, {req, " R7 busy before sync latency"});
      @(negedge clk);
      chk(int'(busy), 0, {req, " R7 busy released"});
      hv_set(1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(int'(set_pulse), 0, "R1 set_pulse reset");
      chk(int'(clr_pulse), 0, "R1 clr_pulse reset");
      chk(int'(busy), 0, "R1 busy reset");
      rst_n = 1'b1;
      hv_set(1'b1);
      // R1: a write right after reset has no armed write-enable.
      txn(1'b0, 1, 0, 1'b0, 0, "R1");

      txn(1'b1, 1, 0, 1'b0, 1, "R2");
      chk(int'(busy), 1, "R2 busy after raise");
      finish_hold("R2");

      txn(1'b1, 3, 0, 1'b0, 2, "R3");
      chk(int'(busy), 1, "R3 busy after restore");
      finish_hold("R3");

      txn(1'b0, 3, 0, 1'b0, 0, "R4");
      chk(int'(busy), 0, "R4 no busy");

      txn(1'b1, 1, 8'h5A, 1'b0, 0, "R5 data");
      txn(1'b1, 2, 0, 1'b0, 0, "R5 addr 02h");
      txn(1'b1, 8'h81, 0, 1'b0, 0, "R5 addr 81h");
      chk(int'(busy), 0, "R5 no busy");

      // R8: the previous frames disarmed the write-enable.
      txn(1'b1, 4, 0, 1'b0, 0, "R8 plain write");
      txn(1'b0, 1, 0, 1'b0, 0, "R8 no re-arm");

      txn(1'b1, 3, 0, 1'b1, 0, "R6 flag drop");
      chk(int'(busy), 0, "R6 no busy");
      hv_set(1'b1);
      hv_set(1'b0);
      txn(1'b1, 1, 0, 1'b0, 0, "R6 flag low");
      hv_set(1'b1);

      // R9: commands during busy are ignored.
      txn(1'b1, 1, 0, 1'b0, 1, "R9 start");
      txn(1'b1, 3, 0, 1'b0, 0, "R9 during busy");
      chk(int'(busy), 1, "R9 still busy");
      finish_hold("R9");
      txn(1'b0, 3, 0, 1'b0, 0, "R9 nothing armed");

      txn(1'b1, 3, 0, 1'b0, 2, "R10 final");
      finish_hold("R10");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule